// File: doc/BRIEF.md
# Text Raster Fetch Generator

This block drives a character-cell text display from a single pixel clock. It keeps horizontal and vertical scan counters and, for every pixel position, computes which byte of a 128-column wrapping virtual screen is on show. The window onto that screen is set by a 5-bit first-row register and a 7-bit first-column register. The block presents the cell address to the character and attribute memories. From the returned character code and the current scanline inside the cell, it forms a glyph ROM address. It then shifts the glyph byte out as 2-bit pixels with three levels: off, normal and dim.

Two horizontal densities exist. Wide characters show 52 cells per line, with every glyph pixel held for two clocks. Narrow characters show 104 cells per line, with one clock per pixel; in this mode the start column is masked and can be pulled left by eight cells. Narrow mode needs both the option-fitted input and the resolution input. The block also produces a vertical blank flag, and it passes a beep enable through only on two scanlines of each cell, which chops the tone.

All memories are external and synchronous, with one clock of read latency. Addresses are formed afresh on every clock, so the pixel stream runs without gaps.

Top module: `text_raster_gen`

## Requirements
- R1: `vblank` is 0 for the first VIS_LINES*LINE_CLKS clocks of each frame and 1 for the remaining (FRAME_LINES-VIS_LINES)*LINE_CLKS clocks. It lags the scan position by one clock, and the frame repeats every LINE_CLKS*FRAME_LINES clocks after reset.
- R2: For scan line v and cell index x, `vram_addr` = {(scroll_row + v/CELL_H) mod 32, (col + x) mod 128}. The row sits in bits 11:7 and the column in bits 6:0.
- R3: Narrow mode is active only when `option_fitted` and `hires_sel` are both 1. In narrow mode col = scroll_col & 0x60, and cell x covers 8 clocks starting at clock 8x, for 104 cells.
- R4: In all other cases (wide mode), col = scroll_col. Cell x covers 16 clocks starting at clock 16x, and each glyph pixel lasts two clocks, for 52 cells.
- R5: In narrow mode with `shift_left` = 1, col is reduced by 8, modulo 128.
- R6: `glyph_addr` = {scanline within cell (bits 10:7), char[6:0] (bits 6:0)}. When char bit 7 is 1 on the last scanline of the cell (CELL_H-1), the glyph byte is replaced by 0xFF.
- R7: Glyph bits are sent MSB first. A 1 bit gives pixel 2 when the attribute bit is 1 and pixel 1 otherwise. A 0 bit gives pixel 0, and pixel 3 never occurs.
- R8: `pixel` is 0 on lines at or beyond VIS_LINES and at clocks at or beyond ACT_PIX within a line.
- R9: `beep_out` equals `beep_en` only on visible scanlines whose row within the cell is 2 or 6, and is 0 everywhere else. It lags by one clock.
- R10: The pixel for scan position p appears exactly 5 clocks after the counters reach p, given memories with one clock of read latency. Output continues without gaps.
- R11: While `rst_n` is 0, `pixel`, `vblank`, `beep_out`, `vram_addr` and `glyph_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scroll_row | input | 5 | First text row of the window |
| scroll_col | input | 7 | First column of the window |
| hires_sel | input | 1 | Requests narrow characters |
| shift_left | input | 1 | Narrow mode: window moved left 8 cells |
| option_fitted | input | 1 | Narrow-mode option present |
| char_data | input | 8 | Character byte, one clock after vram_addr |
| attr_bit | input | 1 | Attribute (dim) bit, one clock after vram_addr |
| glyph_data | input | 8 | Glyph row byte, one clock after glyph_addr |
| beep_en | input | 1 | Audio tone enable |
| vram_addr | output | 12 | Character/attribute memory address |
| glyph_addr | output | 11 | Glyph ROM address |
| pixel | output | 2 | Pixel level: 0 off, 1 normal, 2 dim |
| vblank | output | 1 | High outside the visible lines |
| beep_out | output | 1 | Gated tone output |

## Verification
Each full frame is compared pixel by pixel against a model of the address and glyph rules. The memories hold contents derived from the address, so any error in address, column or row shows up as a wrong pixel. Wide mode with a small column offset is set against narrow mode with a column value whose low bits must be masked away, and against narrow mode with the left shift, where the column wraps below zero. Turning the option off while the resolution bit is still set must give wide output, and a first row of 31 checks the row wrap from 31 to 0. The memory contents set bit 7 of the character and the attribute bit in varied cells, so underline, dim and normal pixels all appear. Running the beep enable both on and off separates the scanline gating from a plain pass-through.

// File: rtl/text_raster_pkg.sv
// Shared types for the text raster fetch generator.
// Assumes glyphs are 8 pixels wide, so a 3-bit pixel select is enough.
package text_raster_pkg;
    localparam int BSEL_W = 3;

    // Position tag that travels down the fetch pipeline beside the data.
    typedef struct packed {
        logic              vis;
        logic [BSEL_W-1:0] bsel;
    } pix_tag_t;

    // Cell flags captured once the character byte has returned.
    typedef struct packed {
        pix_tag_t tag;
        logic     ul;
        logic     dim;
    } pix_stage_t;

    typedef enum logic [1:0] {
        PIX_OFF  = 2'd0,
        PIX_NORM = 2'd1,
        PIX_DIM  = 2'd2
    } pix_level_e;
endpackage

// File: rtl/text_raster_timing.sv
// Scan counters: clock within the line, line within the frame, and the
// scanline within a cell plus the text row, both kept by stepping so that
// no divider is needed. Assumes FRAME_LINES > VIS_LINES and CELL_H >= 2.
module text_raster_timing #(
    parameter int LINE_CLKS   = 1024,
    parameter int FRAME_LINES = 260,
    parameter int VIS_LINES   = 240,
    parameter int CELL_H      = 10,
    parameter int H_W         = $clog2(LINE_CLKS),
    parameter int SL_W        = $clog2(CELL_H),
    parameter int ROW_W       = $clog2(FRAME_LINES / CELL_H + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [H_W-1:0]   h_cnt,
    output logic [SL_W-1:0]  sl_cnt,
    output logic [ROW_W-1:0] row_cnt,
    output logic             vis_line
);
    localparam int V_W = $clog2(FRAME_LINES);

    logic [V_W-1:0] v_cnt;

    // Step the clock, line, scanline-in-cell and row counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt   <= '0;
            v_cnt   <= '0;
            sl_cnt  <= '0;
            row_cnt <= '0;
        end else if (h_cnt == H_W'(LINE_CLKS - 1)) begin
            h_cnt <= '0;
            if (v_cnt == V_W'(FRAME_LINES - 1)) begin
                v_cnt   <= '0;
                sl_cnt  <= '0;
                row_cnt <= '0;
            end else begin
                v_cnt <= v_cnt + 1'b1;
                if (sl_cnt == SL_W'(CELL_H - 1)) begin
                    sl_cnt  <= '0;
                    row_cnt <= row_cnt + 1'b1;
                end else begin
                    sl_cnt <= sl_cnt + 1'b1;
                end
            end
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    // Visible-line decode.
    always_comb vis_line = (v_cnt < V_W'(VIS_LINES));
endmodule

// File: rtl/text_raster_addr.sv
// Address stage: turns the scan position and window registers into a
// video RAM cell address, and tags it with visibility and the pixel select.
// Assumes 8-pixel glyphs and a power-of-two virtual screen width.
module text_raster_addr
    import text_raster_pkg::*;
#(
    parameter int H_W         = 10,
    parameter int SL_W        = 4,
    parameter int ROW_W       = 5,
    parameter int SROW_W      = 5,
    parameter int COL_W       = 7,
    parameter int ACT_PIX     = 832,
    parameter int HI_COL_MASK = 'h60,
    parameter int SHIFT_CELLS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [H_W-1:0]          h_cnt,
    input  logic [SL_W-1:0]         sl_cnt,
    input  logic [ROW_W-1:0]        row_cnt,
    input  logic                    vis_line,
    input  logic [SROW_W-1:0]       scroll_row,
    input  logic [COL_W-1:0]        scroll_col,
    input  logic                    hires_sel,
    input  logic                    shift_left,
    input  logic                    option_fitted,
    output logic [SROW_W+COL_W-1:0] vram_addr,
    output pix_tag_t                tag_q,
    output logic [SL_W-1:0]         sl_q
);
    logic              narrow;
    logic [COL_W-1:0]  x_idx, base_col, cell_col;
    logic [SROW_W-1:0] row_sel;
    pix_tag_t          tag_d;

    // Pick the cell index, pixel select and window column for the mode.
    always_comb begin
        narrow = option_fitted & hires_sel;
        if (narrow) begin
            x_idx      = COL_W'(h_cnt >> BSEL_W);
            tag_d.bsel = h_cnt[BSEL_W-1:0];
            base_col   = (scroll_col & COL_W'(HI_COL_MASK))
                       - (shift_left ? COL_W'(SHIFT_CELLS) : '0);
        end else begin
            x_idx      = COL_W'(h_cnt >> (BSEL_W + 1));
            tag_d.bsel = h_cnt[BSEL_W:1];
            base_col   = scroll_col;
        end
        cell_col  = base_col + x_idx;
        row_sel   = scroll_row + SROW_W'(row_cnt);
        tag_d.vis = vis_line && (h_cnt < H_W'(ACT_PIX));
    end

    // Register the address with its tag and scanline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vram_addr <= '0;
            tag_q     <= '0;
            sl_q      <= '0;
        end else begin
            vram_addr <= {row_sel, cell_col};
            tag_q     <= tag_d;
            sl_q      <= sl_cnt;
        end
    end
endmodule

// File: rtl/text_raster_pixel.sv
// Glyph and pixel stages: takes the character byte one clock after the
// cell address, issues the glyph ROM address, and on glyph return picks
// one bit and maps it to a level. Assumes one-clock synchronous memories.
module text_raster_pixel
    import text_raster_pkg::*;
#(
    parameter int SL_W   = 4,
    parameter int CELL_H = 10,
    parameter int CHAR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  pix_tag_t               tag_in,
    input  logic [SL_W-1:0]        sl_in,
    input  logic [CHAR_W-1:0]      char_data,
    input  logic                   attr_bit,
    input  logic [7:0]             glyph_data,
    output logic [SL_W+CHAR_W-2:0] glyph_addr,
    output logic [1:0]             pixel
);
    pix_tag_t        tag2;
    logic [SL_W-1:0] sl2;
    pix_stage_t      st3, st4;
    logic [7:0]      gl;
    logic            lit;

    // Wait one clock for the character memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag2 <= '0;
            sl2  <= '0;
        end else begin
            tag2 <= tag_in;
            sl2  <= sl_in;
        end
    end

    // Form the glyph address, latch the underline and dim flags, then
    // carry them across the glyph ROM read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glyph_addr <= '0;
            st3        <= '0;
            st4        <= '0;
        end else begin
            glyph_addr <= {sl2, char_data[CHAR_W-2:0]};
            st3.tag    <= tag2;
            st3.ul     <= char_data[CHAR_W-1] && (sl2 == SL_W'(CELL_H - 1));
            st3.dim    <= attr_bit;
            st4        <= st3;
        end
    end

    // Select the glyph bit, MSB first.
    always_comb begin
        gl  = st4.ul ? 8'hFF : glyph_data;
        lit = gl[~st4.tag.bsel];
    end

    // Register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pixel <= PIX_OFF;
        else if (!st4.tag.vis || !lit) pixel <= PIX_OFF;
        else                         pixel <= st4.dim ? PIX_DIM : PIX_NORM;
    end
endmodule

// File: rtl/text_raster_gen.sv
// Top level of the text raster fetch generator: scan counters, address
// stage, glyph/pixel stages, and the registered blank flag and beep gate.
// Assumes external synchronous memories with one clock of read latency.
module text_raster_gen
    import text_raster_pkg::*;
#(
    parameter int LINE_CLKS   = 1024,
    parameter int FRAME_LINES = 260,
    parameter int VIS_LINES   = 240,
    parameter int CELL_H      = 10,
    parameter int ACT_PIX     = 832,
    parameter int SROW_W      = 5,
    parameter int COL_W       = 7,
    parameter int CHAR_W      = 8,
    parameter int BEEP_ROW_A  = 2,
    parameter int BEEP_ROW_B  = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [SROW_W-1:0]               scroll_row,
    input  logic [COL_W-1:0]                scroll_col,
    input  logic                            hires_sel,
    input  logic                            shift_left,
    input  logic                            option_fitted,
    input  logic [CHAR_W-1:0]               char_data,
    input  logic                            attr_bit,
    input  logic [7:0]                      glyph_data,
    input  logic                            beep_en,
    output logic [SROW_W+COL_W-1:0]         vram_addr,
    output logic [$clog2(CELL_H)+CHAR_W-2:0] glyph_addr,
    output logic [1:0]                      pixel,
    output logic                            vblank,
    output logic                            beep_out
);
    localparam int H_W   = $clog2(LINE_CLKS);
    localparam int SL_W  = $clog2(CELL_H);
    localparam int ROW_W = $clog2(FRAME_LINES / CELL_H + 1);
    localparam int GA_W  = SL_W + CHAR_W - 1;

    logic [H_W-1:0]   h_cnt;
    logic [SL_W-1:0]  sl_cnt, sl_q;
    logic [ROW_W-1:0] row_cnt;
    logic             vis_line;
    pix_tag_t         tag_q;

    text_raster_timing #(
        .LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES),
        .VIS_LINES(VIS_LINES), .CELL_H(CELL_H),
        .H_W(H_W), .SL_W(SL_W), .ROW_W(ROW_W)
    ) timing_i (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .sl_cnt(sl_cnt),
        .row_cnt(row_cnt), .vis_line(vis_line)
    );

    text_raster_addr #(
        .H_W(H_W), .SL_W(SL_W), .ROW_W(ROW_W), .SROW_W(SROW_W),
        .COL_W(COL_W), .ACT_PIX(ACT_PIX)
    ) addr_i (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .sl_cnt(sl_cnt),
        .row_cnt(row_cnt), .vis_line(vis_line), .scroll_row(scroll_row),
        .scroll_col(scroll_col), .hires_sel(hires_sel),
        .shift_left(shift_left), .option_fitted(option_fitted),
        .vram_addr(vram_addr), .tag_q(tag_q), .sl_q(sl_q)
    );

    text_raster_pixel #(
        .SL_W(SL_W), .CELL_H(CELL_H), .CHAR_W(CHAR_W)
    ) pixel_i (
        .clk(clk), .rst_n(rst_n), .tag_in(tag_q), .sl_in(sl_q),
        .char_data(char_data), .attr_bit(attr_bit),
        .glyph_data(glyph_data), .glyph_addr(glyph_addr), .pixel(pixel)
    );

    // Blank flag and beep gate, one clock behind the counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vblank   <= 1'b0;
            beep_out <= 1'b0;
        end else begin
            vblank   <= !vis_line;
            beep_out <= beep_en && vis_line &&
                        (sl_cnt == SL_W'(BEEP_ROW_A) || sl_cnt == SL_W'(BEEP_ROW_B));
        end
    end
endmodule

// File: rtl/text_raster_chk.sv
// Checker for the text raster fetch generator, attached by bind.
// Assumes the 5-clock pixel and 1-clock flag latencies of the design.
module text_raster_chk #(
    parameter int CELL_H = 10,
    parameter int GA_W   = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      pixel,
    input logic            vblank,
    input logic            beep_en,
    input logic            beep_out,
    input logic [GA_W-1:0] glyph_addr
);
    localparam int SL_W = $clog2(CELL_H);

    assert_pix_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pixel != 2'b11);

    assert_blank_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && $past(vblank, 4)) |-> (pixel == 2'b00));

    assert_beep_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beep_out |-> $past(beep_en));

    assert_beep_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beep_out |-> !vblank);

    assert_glyph_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        glyph_addr[GA_W-1 -: SL_W] < SL_W'(CELL_H));
endmodule

bind text_raster_gen text_raster_chk #(.CELL_H(CELL_H), .GA_W(GA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pixel(pixel), .vblank(vblank),
    .beep_en(beep_en), .beep_out(beep_out), .glyph_addr(glyph_addr)
);

// File: tb/text_raster_gen_tb_top.sv
`timescale 1ns/1ps
module text_raster_gen_tb_top;
    localparam int LINE  = 1024;
    localparam int FRM   = 22;
    localparam int VIS   = 20;
    localparam int CH    = 10;
    localparam int ACT   = 832;
    localparam int FCYC  = LINE * FRM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  scroll_row = '0;
    logic [6:0]  scroll_col = '0;
    logic        hires_sel = 1'b0, shift_left = 1'b0, option_fitted = 1'b0;
    logic [7:0]  char_data = '0;
    logic        attr_bit = 1'b0;
    logic [7:0]  glyph_data = '0;
    logic        beep_en = 1'b0;
    logic [11:0] vram_addr;
    logic [10:0] glyph_addr;
    logic [1:0]  pixel;
    logic        vblank, beep_out;

    int checks = 0;
    int errors = 0;
    int k = 0;

    always #2.5 clk = ~clk;

    text_raster_gen #(
        .LINE_CLKS(LINE), .FRAME_LINES(FRM), .VIS_LINES(VIS),
        .CELL_H(CH), .ACT_PIX(ACT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .scroll_row(scroll_row),
        .scroll_col(scroll_col), .hires_sel(hires_sel),
        .shift_left(shift_left), .option_fitted(option_fitted),
        .char_data(char_data), .attr_bit(attr_bit), .glyph_data(glyph_data),
        .beep_en(beep_en), .vram_addr(vram_addr), .glyph_addr(glyph_addr),
        .pixel(pixel), .vblank(vblank), .beep_out(beep_out)
    );

    // Memory contents derived from the address.
    function automatic logic [7:0] char_fn(logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction
    function automatic logic attr_fn(logic [11:0] a);
        return a[2] ^ a[8] ^ a[5];
    endfunction
    function automatic logic [7:0] glyph_fn(logic [10:0] g);
        logic [7:0] t;
        t = g[7:0] ^ {g[10:7], 1'b0, g[2:0]};
        return t * 8'd13 + 8'd7;
    endfunction

    // Synchronous memories, one clock of read latency.
    always @(posedge clk) begin
        char_data  <= char_fn(vram_addr);
        attr_bit   <= attr_fn(vram_addr);
        glyph_data <= glyph_fn(glyph_addr);
    end

    // Clocks since reset release equal the scan position.
    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    function automatic logic [1:0] exp_pix(int p);
        int pos, v, h, x, b, col, addr, sl;
        logic narrow;
        logic [7:0] ch, g;
        pos = p % FCYC; v = pos / LINE; h = pos % LINE;
        if (p < 0 || v >= VIS || h >= ACT) return 2'd0;
        narrow = option_fitted & hires_sel;
        x   = narrow ? h / 8 : h / 16;
        b   = narrow ? h % 8 : (h % 16) / 2;
        col = narrow ? (((scroll_col & 7'h60) - (shift_left ? 8 : 0)) & 127) : scroll_col;
        addr = (((scroll_row + v / CH) % 32) << 7) | ((col + x) % 128);
        ch = char_fn(12'(addr));
        sl = v % CH;
        g  = (ch[7] && sl == CH - 1) ? 8'hFF : glyph_fn({4'(sl), ch[6:0]});
        if (!g[7 - b]) return 2'd0;
        return attr_fn(12'(addr)) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic exp_vb(int p);
        return ((p % FCYC) / LINE) >= VIS;
    endfunction

    function automatic logic exp_beep(int p);
        int v;
        v = (p % FCYC) / LINE;
        return beep_en && v < VIS && ((v % CH) == 2 || (v % CH) == 6);
    endfunction

    task automatic check(string what, logic ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Set inputs during vertical blank, then compare one full frame.
    task automatic run_frame(string tags, logic o, logic r, logic s, logic be,
                             int srow, int scol);
        int bp = 0, bv = 0, bb = 0;
        int pa = 0, pe = 0, va = 0, ve = 0, ba = 0, bexp = 0;
        while ((k % FCYC) != VIS * LINE + 16) @(negedge clk);
        option_fitted = o; hires_sel = r; shift_left = s; beep_en = be;
        scroll_row = 5'(srow); scroll_col = 7'(scol);
        for (int i = 0; i < FCYC; i++) begin
            @(negedge clk);
            if (pixel !== exp_pix(k - 5)) begin
                if (bp == 0) begin pa = pixel; pe = exp_pix(k - 5); end
                bp++;
            end
            if (vblank !== exp_vb(k - 1)) begin
                if (bv == 0) begin va = vblank; ve = exp_vb(k - 1); end
                bv++;
            end
            if (beep_out !== exp_beep(k - 1)) begin
                if (bb == 0) begin ba = beep_out; bexp = exp_beep(k - 1); end
                bb++;
            end
        end
        check({"pixel stream ", tags}, bp == 0, pa, pe);
        check({"vblank R1 ", tags}, bv == 0, va, ve);
        check({"beep R9 ", tags}, bb == 0, ba, bexp);
    endtask

    task automatic test_reset_r11;
        repeat (3) @(negedge clk);
        check("R11 pixel in reset", pixel == 2'd0, pixel, 0);
        check("R11 vblank in reset", vblank == 1'b0, vblank, 0);
        check("R11 beep in reset", beep_out == 1'b0, beep_out, 0);
        check("R11 addresses in reset", vram_addr == '0 && glyph_addr == '0,
              {vram_addr, glyph_addr}, 0);
        rst_n = 1'b1;
    endtask

    task automatic test_wide_basic;
        run_frame("R2 R4 R6 R7 R8 R10 wide", 1'b1, 1'b0, 1'b0, 1'b1, 0, 5);
    endtask
    task automatic test_narrow_mask;
        run_frame("R3 R6 R7 narrow mask", 1'b1, 1'b1, 1'b0, 1'b1, 3, 'h35);
    endtask
    task automatic test_narrow_shift;
        run_frame("R5 narrow shift wrap", 1'b1, 1'b1, 1'b1, 1'b1, 1, 'h05);
    endtask
    task automatic test_option_absent;
        run_frame("R3 option absent gives wide", 1'b0, 1'b1, 1'b1, 1'b1, 2, 'h44);
    endtask
    task automatic test_row_wrap;
        run_frame("R2 row wrap 31 to 0", 1'b1, 1'b0, 1'b0, 1'b1, 31, 'h7E);
    endtask
    task automatic test_beep_off;
        run_frame("R9 beep disabled", 1'b1, 1'b1, 1'b0, 1'b0, 7, 'h60);
    endtask

    initial begin
        test_reset_r11();
        test_wide_basic();
        test_narrow_mask();
        test_narrow_shift();
        test_option_absent();
        test_row_wrap();
        test_beep_off();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", k, FCYC * 7);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule